// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two guesses are formed in parallel. The first comes from a two-level per-branch scheme: a small table of recent outcomes, selected by fetch address bits, chooses a saturating counter. The second comes from a shared register of the most recent outcomes of all branches, which chooses a counter in a second counter table. A third table of saturating counters, also selected by fetch address bits, decides which of the two guesses is reported.

The lookup is purely combinational. The fetch stage presents a PC and receives the prediction in the same cycle. It also receives the local history and global history values that produced the prediction. The fetch stage carries these two values down the pipeline with the branch. When the branch resolves, the back end returns the PC, the actual outcome and the two carried history values. The block then trains all of its tables in a single clock edge.

Top module: `tournament_bp`

## Requirements
- R1: While reset is held and directly after it, every counter holds 01 and every history holds 000. For any PC, `pred_taken_o`, `local_pred_o` and `global_pred_o` are 0, and `lhist_o` and `ghist_o` are 0.
- R2: `lhist_o` is the 3-bit local history entry selected by `pc_i[4:2]`. On a valid resolve, the entry selected by `res_pc_i[4:2]` becomes `{old[1:0], res_taken_i}`, where 1 means taken. No other entry changes.
- R3: `ghist_o` is the global history register. On every valid resolve it becomes `{old[1:0], res_taken_i}`.
- R4: `local_pred_o` is bit 1 of the local pattern counter at index `lhist_o`. On a valid resolve, the counter at `res_lhist_i` counts up if the branch was taken and down if not, and stays within 00 and 11.
- R5: `global_pred_o` is bit 1 of the global counter at index `ghist_o`. On a valid resolve, the counter at `res_ghist_i` counts up if the branch was taken and down if not, and stays within 00 and 11.
- R6: `pred_taken_o` equals `global_pred_o` when bit 1 of the chooser counter at `pc_i[4:2]` is 1. Otherwise it equals `local_pred_o`.
- R7: On a valid resolve, the chooser counter at `res_pc_i[4:2]` changes only if the local counter at `res_lhist_i` and the global counter at `res_ghist_i` have different bit 1 values. It then steps up when the global guess matches `res_taken_i` and down otherwise, and stays within 00 and 11.
- R8: A resolve in the same cycle as a lookup does not alter that lookup's outputs. Its effect appears from the next cycle on.
- R9: While `res_valid_i` is 0, no table or history changes, whatever the other resolve inputs carry.
- R10: PC bits other than [4:2] have no effect on lookup or training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Fetch PC for lookup |
| pred_taken_o | output | 1 | Final taken prediction |
| local_pred_o | output | 1 | Local component guess |
| global_pred_o | output | 1 | Global component guess |
| lhist_o | output | 3 | Local history used by this lookup |
| ghist_o | output | 3 | Global history used by this lookup |
| res_valid_i | input | 1 | Resolve strobe |
| res_pc_i | input | 32 | PC of the resolving branch |
| res_taken_i | input | 1 | Actual outcome, 1 is taken |
| res_lhist_i | input | 3 | Local history carried from the lookup |
| res_ghist_i | input | 3 | Global history carried from the lookup |

## Verification
A lookup and a resolve can occur in the same cycle, often for the same table entries. The bench drives both ports on almost every cycle. The lookup PC and the resolve PC frequently share bits [4:2], and the returned history indices often equal the ones the lookup reads. The bench reads the lookup outputs before the clock edge and compares them with a model that has not yet applied that cycle's training. It then applies the training and checks the outputs again on the next cycle. Some resolves carry deliberately stale history indices, so the bench can confirm that training uses the carried indices and not the current state.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int unsigned CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_RST = ctr_t'(1);
  localparam ctr_t CTR_MAX = '1;

  function automatic ctr_t ctr_next(ctr_t c, logic up);
    if (up) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    else    return (c == '0) ? c : c - ctr_t'(1);
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd0_idx_i,
  output ctr_t             rd0_o,
  input  logic [IDX_W-1:0] rd1_idx_i,
  output ctr_t             rd1_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_up_i
);
  ctr_t ctr_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctr_q[i] <= CTR_RST;
      else if (upd_en_i && upd_idx_i == IDX_W'(i)) ctr_q[i] <= ctr_next(ctr_q[i], upd_up_i);
    end
  end

  assign rd0_o = ctr_q[rd0_idx_i];
  assign rd1_o = ctr_q[rd1_idx_i];
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned H_W   = 3,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [H_W-1:0]   rd_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_bit_i
);
  logic [H_W-1:0] hist_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[i] <= '0;
      else if (upd_en_i && upd_idx_i == IDX_W'(i))
        hist_q[i] <= (H_W > 1) ? {hist_q[i][H_W-2:0], upd_bit_i} : H_W'(upd_bit_i);
    end
  end

  assign rd_o = hist_q[rd_idx_i];
endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
  parameter int unsigned H_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           bit_i,
  output logic [H_W-1:0] hist_o
);
  logic [H_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= (H_W > 1) ? {hist_q[H_W-2:0], bit_i} : H_W'(bit_i);
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import tbp_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_LSB   = 2,
  parameter int unsigned PC_IDX_W = 3,
  parameter int unsigned LH_W     = 3,
  parameter int unsigned GH_W     = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pc_i,
  output logic            pred_taken_o,
  output logic            local_pred_o,
  output logic            global_pred_o,
  output logic [LH_W-1:0] lhist_o,
  output logic [GH_W-1:0] ghist_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [LH_W-1:0] res_lhist_i,
  input  logic [GH_W-1:0] res_ghist_i
);
  localparam int unsigned PC_MSB = PC_LSB + PC_IDX_W - 1;

  logic [PC_IDX_W-1:0] lk_idx, rs_idx;
  assign lk_idx = pc_i[PC_MSB:PC_LSB];
  assign rs_idx = res_pc_i[PC_MSB:PC_LSB];

  logic [LH_W-1:0] lhist;
  logic [GH_W-1:0] ghist;
  ctr_t lpt_lk, lpt_rs, gpt_lk, gpt_rs, cho_lk, cho_rs;
  logic loc_rs, glb_rs, cho_en;

  tbp_hist_table #(.IDX_W(PC_IDX_W), .H_W(LH_W)) u_lht (
    .clk_i, .rst_ni,
    .rd_idx_i (lk_idx),
    .rd_o     (lhist),
    .upd_en_i (res_valid_i),
    .upd_idx_i(rs_idx),
    .upd_bit_i(res_taken_i)
  );

  tbp_ghr #(.H_W(GH_W)) u_ghr (
    .clk_i, .rst_ni,
    .shift_i(res_valid_i),
    .bit_i  (res_taken_i),
    .hist_o (ghist)
  );

  tbp_ctr_table #(.IDX_W(LH_W)) u_lpt (
    .clk_i, .rst_ni,
    .rd0_idx_i(lhist),       .rd0_o(lpt_lk),
    .rd1_idx_i(res_lhist_i), .rd1_o(lpt_rs),
    .upd_en_i (res_valid_i),
    .upd_idx_i(res_lhist_i),
    .upd_up_i (res_taken_i)
  );

  tbp_ctr_table #(.IDX_W(GH_W)) u_gpt (
    .clk_i, .rst_ni,
    .rd0_idx_i(ghist),       .rd0_o(gpt_lk),
    .rd1_idx_i(res_ghist_i), .rd1_o(gpt_rs),
    .upd_en_i (res_valid_i),
    .upd_idx_i(res_ghist_i),
    .upd_up_i (res_taken_i)
  );

  // chooser trains only when the components disagreed
  assign loc_rs = lpt_rs[CTR_W-1];
  assign glb_rs = gpt_rs[CTR_W-1];
  assign cho_en = res_valid_i && (loc_rs != glb_rs);

  tbp_ctr_table #(.IDX_W(PC_IDX_W)) u_cho (
    .clk_i, .rst_ni,
    .rd0_idx_i(lk_idx), .rd0_o(cho_lk),
    .rd1_idx_i(rs_idx), .rd1_o(cho_rs),
    .upd_en_i (cho_en),
    .upd_idx_i(rs_idx),
    .upd_up_i (glb_rs == res_taken_i)
  );

  logic unused_cho_rs;
  assign unused_cho_rs = ^cho_rs;

  assign lhist_o       = lhist;
  assign ghist_o       = ghist;
  assign local_pred_o  = lpt_lk[CTR_W-1];
  assign global_pred_o = gpt_lk[CTR_W-1];
  assign pred_taken_o  = cho_lk[CTR_W-1] ? global_pred_o : local_pred_o;
endmodule

// File: rtl/tournament_bp_chk.sv
module tournament_bp_chk #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_LSB   = 2,
  parameter int unsigned PC_IDX_W = 3,
  parameter int unsigned LH_W     = 3,
  parameter int unsigned GH_W     = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] pc_i,
  input logic            pred_taken_o,
  input logic            local_pred_o,
  input logic            global_pred_o,
  input logic [LH_W-1:0] lhist_o,
  input logic [GH_W-1:0] ghist_o,
  input logic            res_valid_i,
  input logic [PC_W-1:0] res_pc_i,
  input logic            res_taken_i,
  input logic [LH_W-1:0] res_lhist_i,
  input logic [GH_W-1:0] res_ghist_i
);
  localparam int unsigned PC_MSB = PC_LSB + PC_IDX_W - 1;

  a_r1_reset_ghist: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (ghist_o == '0 && lhist_o == '0));

  a_r3_ghist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> ghist_o == {$past(ghist_o[GH_W-2:0]), $past(res_taken_i)});

  a_r9_ghist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(ghist_o));

  a_r2_lhist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && pc_i[PC_MSB:PC_LSB] == res_pc_i[PC_MSB:PC_LSB])
    |=> (pc_i[PC_MSB:PC_LSB] != $past(pc_i[PC_MSB:PC_LSB])) ||
        (lhist_o == {$past(lhist_o[LH_W-2:0]), $past(res_taken_i)}));

  a_r9_lhist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> (pc_i[PC_MSB:PC_LSB] != $past(pc_i[PC_MSB:PC_LSB])) || $stable(lhist_o));

  logic unused;
  assign unused = pred_taken_o ^ local_pred_o ^ global_pred_o ^ ^res_lhist_i ^ ^res_ghist_i;
endmodule

bind tournament_bp tournament_bp_chk #(
  .PC_W(PC_W), .PC_LSB(PC_LSB), .PC_IDX_W(PC_IDX_W), .LH_W(LH_W), .GH_W(GH_W)
) u_chk (.*);

// File: tb/tb_tournament_bp.sv
`timescale 1ns/1ps
module tb_tournament_bp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0;
  logic        pred_taken_o, local_pred_o, global_pred_o;
  logic [2:0]  lhist_o, ghist_o;
  logic        res_valid_i = 1'b0;
  logic [31:0] res_pc_i = '0;
  logic        res_taken_i = 1'b0;
  logic [2:0]  res_lhist_i = '0, res_ghist_i = '0;

  tournament_bp dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [2:0] m_lht [8];
  logic [1:0] m_lpt [8], m_gpt [8], m_cho [8];
  logic [2:0] m_ghr;

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_lht[i] = '0; m_lpt[i] = 2'd1; m_gpt[i] = 2'd1; m_cho[i] = 2'd1;
    end
    m_ghr = '0;
  endtask

  task automatic check_lookup(string tag);
    logic [2:0] ix, lh;
    logic lp, gp;
    ix = pc_i[4:2];
    lh = m_lht[ix];
    lp = m_lpt[lh][1];
    gp = m_gpt[m_ghr][1];
    chk({tag, " R2 R10 lhist"}, lhist_o, lh);
    chk({tag, " R3 ghist"}, ghist_o, m_ghr);
    chk({tag, " R4 local"}, local_pred_o, lp);
    chk({tag, " R5 global"}, global_pred_o, gp);
    chk({tag, " R6 R7 pred"}, pred_taken_o, m_cho[ix][1] ? gp : lp);
  endtask

  task automatic model_train();
    logic [2:0] ix;
    logic lp, gp, t;
    if (!res_valid_i) return;
    ix = res_pc_i[4:2];
    t  = res_taken_i;
    lp = m_lpt[res_lhist_i][1];
    gp = m_gpt[res_ghist_i][1];
    if (lp != gp) m_cho[ix] = sat(m_cho[ix], gp == t);
    m_lpt[res_lhist_i] = sat(m_lpt[res_lhist_i], t);
    m_gpt[res_ghist_i] = sat(m_gpt[res_ghist_i], t);
    m_lht[ix] = {m_lht[ix][1:0], t};
    m_ghr = {m_ghr[1:0], t};
  endtask

  // drive at negedge, check before the edge, train the model at the edge
  task automatic step(logic [31:0] pc, logic v, logic [31:0] rpc, logic t,
                      bit stale, string tag);
    @(negedge clk_i);
    pc_i = pc;
    res_valid_i = v;
    res_pc_i = rpc;
    res_taken_i = t;
    res_lhist_i = stale ? 3'($urandom) : m_lht[rpc[4:2]];
    res_ghist_i = stale ? 3'($urandom) : m_ghr;
    #2 check_lookup(tag);
    @(posedge clk_i);
    model_train();
  endtask

  function automatic logic outcome(logic [2:0] ix, int cyc);
    case (ix)
      3'd0, 3'd1: return 1'b1;
      3'd2:       return 1'b0;
      3'd3:       return cyc[0];
      3'd4:       return (cyc % 3) == 0;
      default:    return 1'($urandom);
    endcase
  endfunction

  initial begin
    #3_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    // R1: reset state across every chooser/history index, with upper PC bits varied
    for (int i = 0; i < 8; i++) begin
      pc_i = {24'hA5A5A5, 3'(i), 2'b11} ^ 32'hF000_0000;
      #2;
      chk("R1 pred in reset", pred_taken_o, 0);
      chk("R1 lhist in reset", lhist_o, 0);
      chk("R1 ghist in reset", ghist_o, 0);
      chk("R1 global in reset", global_pred_o, 0);
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) step(32'(i) << 2, 1'b0, '0, 1'b0, 0, "R1 post-reset");

    // R4 R5: saturation at the top, then the bottom, with same-cycle lookup (R8)
    for (int k = 0; k < 6; k++) step(32'h10, 1'b1, 32'h10, 1'b1, 0, "R8 sat-up");
    for (int k = 0; k < 8; k++) step(32'h10, 1'b1, 32'h10, 1'b0, 0, "R8 sat-down");

    // R9: idle resolve port carrying garbage
    for (int k = 0; k < 40; k++)
      step($urandom, 1'b0, $urandom, 1'($urandom), 1, "R9 idle");

    // main sweep: mixed outcome patterns, same-index hits, stale indices
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] rpc, lpc;
      rpc = $urandom;
      lpc = (c % 4 == 0) ? {$urandom, 2'b00} ^ 32'(rpc[4:2]) << 2 : $urandom;
      if (c % 4 == 0) lpc = {lpc[31:5], rpc[4:2], lpc[1:0]};
      step(lpc, ($urandom % 5) != 0, rpc, outcome(rpc[4:2], c),
           ($urandom % 7) == 0, "sweep");
    end

    // R10: resolve via one alias, look up via another
    step(32'hFFFF_FF8C, 1'b1, 32'h0000_000C, 1'b1, 0, "R10 alias");
    step(32'h1234_560C, 1'b0, '0, 1'b0, 0, "R10 alias");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule